// File: doc/BRIEF.md
# Two-Thirds Modular Reduction Selector

This block picks the reduction parameters for one step of an interleaved modular multiplication. An accumulator value Z (two's complement, already moved up by the multiplication shift sZ) and an unsigned modulus N come in together with sZ and a field select. The block finds the relative shift si that places the magnitude of Z between two thirds and four thirds of the modulus, scaled by a power of two. It then picks the sign b that makes the later three-operand addition of b·2^(sZ-si)·N cut Z by at least one bit, and it returns the modulus shift sN = sZ - si in the same output beat. The addition itself is done elsewhere.

No fractions are used. In the prime-field mode every allowed shift k is tested at the same time by checking 2N < 3·|Z|·2^k ≤ 4N, and at most one k can pass. In the binary-field mode Z and N are polynomials with one coefficient per bit, and the shift is the difference of their degrees. If the wanted shift lies outside the configured window, the result is clamped to the nearest edge of the window, a saturation flag is raised and no reduction is requested. A request enters on `in_valid` and its result leaves two cycles later. A new request can be accepted every cycle.

Top module: `modred_select`

## Requirements
- R1: In prime-field mode (`in_binary`=0) with Z nonzero, when some k in [SI_MIN, SI_MAX] satisfies 2N < 3·|Z|·2^k ≤ 4N, `out_si` is that k and `out_sat` is 0. The upper bound is inclusive.
- R2: The sign code on `out_b` is 2'b00 for no reduction, 2'b01 for +1 and 2'b11 for -1. In prime-field mode with an in-range result, b is -1 for positive Z and +1 for negative Z (Z is negative when bit ZW-1 is set).
- R3: `out_sn` equals `in_sz` minus `out_si` as a signed value, and it comes out in the same beat as `out_si` and `out_b`.
- R4: `out_valid` rises exactly two clock cycles after `in_valid` is sampled high, and it is low for cycles where no request was sampled. Back-to-back requests are accepted.
- R5: When Z is zero, in either mode, `out_b` is 2'b00, `out_si` is 0 and `out_sat` is 0.
- R6: In prime-field mode with Z nonzero and no k in the window passing: if 3·|Z|·2^SI_MIN > 4N, then `out_si` = SI_MIN. Otherwise `out_si` = SI_MAX. In both cases `out_sat` is 1 and `out_b` is 2'b00. A zero modulus falls into the first case.
- R7: In binary-field mode (`in_binary`=1) with Z and N nonzero, `out_si` = deg(N) - deg(Z), where deg is the index of the highest set bit. When that value lies within the window, `out_b` is 2'b01 whatever the top bit of Z.
- R8: In binary-field mode, a degree difference outside the window is clamped to the nearest bound with `out_sat` = 1 and `out_b` = 2'b00. A zero modulus with nonzero Z gives SI_MIN with `out_sat` = 1.
- R9: After reset, all outputs are zero.
- R10: For an in-range prime-field result, 3·| |Z|·2^si − N | ≤ N. This means that after the reduction the remainder is at most one third of the shifted modulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_z | input | ZW | Shifted accumulator: two's complement, or polynomial bits in binary mode |
| in_n | input | NW | Modulus, unsigned or polynomial bits |
| in_sz | input | SZW | Multiplication shift sZ, unsigned |
| in_binary | input | 1 | 0 = prime field, 1 = binary field |
| out_valid | output | 1 | Result strobe, two cycles after the request |
| out_b | output | 2 | Reduction sign: 00 none, 01 plus, 11 minus |
| out_si | output | SIW | Relative shift si, signed |
| out_sn | output | SNW | Modulus shift sZ - si, signed |
| out_sat | output | 1 | Shift clamped to the window edge |

## Verification
Saturation and sign choice are settled in the same cycle. A nonzero Z whose sign would otherwise select ±1 must come out with b = 00 when its shift hits a window edge. This is provoked with negative and positive Z whose magnitudes are far above or far below the modulus, in both field modes. The same stream also places values exactly on the inclusive four-thirds boundary, where the bracket and the sign must agree with the neighbouring shift. Each beat is judged against a behavioural loop over all candidate shifts. In-range results are also checked against the one-third remainder bound using the shift the design returned.

// File: rtl/modred_pkg.sv
package modred_pkg;

    typedef enum logic [1:0] {
        B_ZERO  = 2'b00,
        B_PLUS  = 2'b01,
        B_MINUS = 2'b11
    } red_sign_e;

    typedef enum logic {
        FIELD_PRIME  = 1'b0,
        FIELD_BINARY = 1'b1
    } field_e;

    // Sign that cancels the accumulator: negative Z takes +N, positive Z takes -N.
    function automatic red_sign_e cancel_sign(input logic z_negative);
        return z_negative ? B_PLUS : B_MINUS;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/modred_lead1.sv
module modred_lead1 #(
    parameter int W  = 16,
    localparam int PW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic [PW-1:0] pos,
    output logic          any
);
    always_comb begin
        pos = '0;
        any = |vec;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) pos = PW'(i);
        end
    end
endmodule

// File: rtl/modred_bracket.sv
module modred_bracket
    import modred_pkg::*;
#(
    parameter int ZW     = 24,
    parameter int NW     = 20,
    parameter int SI_MIN = -8,
    parameter int SI_MAX = 8,
    parameter int SIW    = 5,
    localparam int NK    = SI_MAX - SI_MIN + 1,
    localparam int SHMAX = max_int(SI_MAX, -SI_MIN),
    localparam int CW    = max_int(ZW, NW) + 3 + SHMAX
) (
    input  logic [ZW-1:0]         mag,
    input  logic [NW-1:0]         modulus,
    output logic [NK-1:0]         hit,
    output logic                  found,
    output logic                  too_big,
    output logic signed [SIW-1:0] si
);
    logic [CW-1:0] t3, n2, n4;

    assign t3 = (CW'(mag) << 1) + CW'(mag);
    assign n2 = CW'(modulus) << 1;
    assign n4 = CW'(modulus) << 2;

    // One comparator pair per candidate shift, all evaluated at once.
    for (genvar i = 0; i < NK; i++) begin : g_k
        localparam int K = SI_MIN + i;
        if (K >= 0) begin : g_up
            assign hit[i] = (n2 < (t3 << K)) && ((t3 << K) <= n4);
        end else begin : g_dn
            assign hit[i] = ((n2 << (-K)) < t3) && (t3 <= (n4 << (-K)));
        end
    end

    if (SI_MIN >= 0) begin : g_big_up
        assign too_big = (t3 << SI_MIN) > n4;
    end else begin : g_big_dn
        assign too_big = t3 > (n4 << (-SI_MIN));
    end

    assign found = |hit;

    always_comb begin
        int acc;
        acc = SI_MIN;
        for (int i = 0; i < NK; i++) begin
            if (hit[i]) acc = SI_MIN + i;
        end
        si = SIW'(acc);
    end
endmodule

// File: rtl/modred_degree.sv
module modred_degree #(
    parameter int ZW     = 24,
    parameter int NW     = 20,
    parameter int SI_MIN = -8,
    parameter int SI_MAX = 8,
    parameter int SIW    = 5,
    localparam int PZ    = (ZW > 1) ? $clog2(ZW) : 1,
    localparam int PN    = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic [ZW-1:0]         zpoly,
    input  logic [NW-1:0]         npoly,
    output logic signed [SIW-1:0] si,
    output logic                  sat
);
    logic [PZ-1:0] z_deg;
    logic [PN-1:0] n_deg;
    logic          z_any, n_any;

    modred_lead1 #(.W(ZW)) u_zdeg (.vec(zpoly), .pos(z_deg), .any(z_any));
    modred_lead1 #(.W(NW)) u_ndeg (.vec(npoly), .pos(n_deg), .any(n_any));

    always_comb begin
        int diff;
        diff = int'(n_deg) - int'(z_deg);
        sat  = 1'b1;
        if (!n_any) begin
            si = SIW'(SI_MIN);
        end else if (!z_any || diff > SI_MAX) begin
            si = SIW'(SI_MAX);
        end else if (diff < SI_MIN) begin
            si = SIW'(SI_MIN);
        end else begin
            si  = SIW'(diff);
            sat = 1'b0;
        end
    end
endmodule

// File: rtl/modred_select.sv
module modred_select
    import modred_pkg::*;
#(
    parameter int ZW     = 24,
    parameter int NW     = 20,
    parameter int SZW    = 5,
    parameter int SI_MIN = -8,
    parameter int SI_MAX = 8,
    localparam int NK    = SI_MAX - SI_MIN + 1,
    localparam int SIW   = $clog2(max_int(SI_MAX, -SI_MIN) + 1) + 1,
    localparam int SNW   = max_int(SZW + 1, SIW) + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [ZW-1:0]         in_z,
    input  logic [NW-1:0]         in_n,
    input  logic [SZW-1:0]        in_sz,
    input  logic                  in_binary,
    output logic                  out_valid,
    output logic [1:0]            out_b,
    output logic signed [SIW-1:0] out_si,
    output logic signed [SNW-1:0] out_sn,
    output logic                  out_sat
);
    typedef struct packed {
        logic                  vld;
        red_sign_e             b;
        logic signed [SIW-1:0] si;
        logic signed [SNW-1:0] sn;
        logic                  sat;
    } result_t;

    // Stage 1: capture the request.
    logic           s1_vld;
    logic [ZW-1:0]  s1_z;
    logic [NW-1:0]  s1_n;
    logic [SZW-1:0] s1_sz;
    field_e         s1_field;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld   <= 1'b0;
            s1_z     <= '0;
            s1_n     <= '0;
            s1_sz    <= '0;
            s1_field <= FIELD_PRIME;
        end else begin
            s1_vld   <= in_valid;
            s1_z     <= in_z;
            s1_n     <= in_n;
            s1_sz    <= in_sz;
            s1_field <= field_e'(in_binary);
        end
    end

    logic [ZW-1:0] mag;
    assign mag = s1_z[ZW-1] ? (~s1_z + 1'b1) : s1_z;

    logic [NK-1:0]         br_hit;
    logic                  br_found, br_too_big;
    logic signed [SIW-1:0] br_si;

    modred_bracket #(
        .ZW(ZW), .NW(NW), .SI_MIN(SI_MIN), .SI_MAX(SI_MAX), .SIW(SIW)
    ) u_bracket (
        .mag(mag), .modulus(s1_n), .hit(br_hit), .found(br_found),
        .too_big(br_too_big), .si(br_si)
    );

    logic signed [SIW-1:0] dg_si;
    logic                  dg_sat;

    modred_degree #(
        .ZW(ZW), .NW(NW), .SI_MIN(SI_MIN), .SI_MAX(SI_MAX), .SIW(SIW)
    ) u_degree (
        .zpoly(s1_z), .npoly(s1_n), .si(dg_si), .sat(dg_sat)
    );

    // Stage 2: merge mode, zero case and saturation; sN is formed here too.
    result_t nxt, res;

    always_comb begin
        nxt     = '0;
        nxt.vld = s1_vld;
        if (s1_z == '0) begin
            nxt.b   = B_ZERO;
            nxt.si  = '0;
            nxt.sat = 1'b0;
        end else if (s1_field == FIELD_BINARY) begin
            nxt.si  = dg_si;
            nxt.sat = dg_sat;
            nxt.b   = dg_sat ? B_ZERO : B_PLUS;
        end else if (br_found) begin
            nxt.si  = br_si;
            nxt.sat = 1'b0;
            nxt.b   = cancel_sign(s1_z[ZW-1]);
        end else begin
            nxt.si  = br_too_big ? SIW'(SI_MIN) : SIW'(SI_MAX);
            nxt.sat = 1'b1;
            nxt.b   = B_ZERO;
        end
        nxt.sn = $signed({{(SNW-SZW){1'b0}}, s1_sz})
               - $signed({{(SNW-SIW){nxt.si[SIW-1]}}, nxt.si});
    end

    always_ff @(posedge clk) begin
        if (rst) res <= '0;
        else     res <= nxt;
    end

    assign out_valid = res.vld;
    assign out_b     = res.b;
    assign out_si    = res.si;
    assign out_sn    = res.sn;
    assign out_sat   = res.sat;

    // R1: at most one candidate shift can bracket the magnitude.
    a_r1_unique_bracket: assert property (@(posedge clk) disable iff (rst)
        s1_vld |-> $onehot0(br_hit));

    // R2: in-range prime result cancels the sign of Z.
    a_r2_sign_cancels: assert property (@(posedge clk) disable iff (rst)
        (s1_vld && s1_field == FIELD_PRIME && s1_z != '0 && br_found)
        |=> (out_b == ($past(s1_z[ZW-1]) ? 2'b01 : 2'b11)));

    // R3: the two shifts always sum to the incoming multiplication shift.
    a_r3_shift_sum: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_sn + SNW'(out_si)) == SNW'($past(s1_sz))));

    // R4: fixed two-cycle latency.
    a_r4_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    // R5: zero accumulator requests nothing.
    a_r5_zero_idle: assert property (@(posedge clk) disable iff (rst)
        (s1_vld && s1_z == '0) |=> (out_b == 2'b00 && !out_sat && out_si == '0));

    // R6 / R8: a clamped shift sits on a window edge and never reduces.
    a_r6_sat_edge: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sat) |-> (out_b == 2'b00 &&
            (out_si == SIW'(SI_MIN) || out_si == SIW'(SI_MAX))));

    // R8: binary mode with a zero modulus clamps low.
    a_r8_binary_zero_mod: assert property (@(posedge clk) disable iff (rst)
        (s1_vld && s1_field == FIELD_BINARY && s1_z != '0 && s1_n == '0)
        |=> (out_sat && out_si == SIW'(SI_MIN)));

endmodule

// File: tb/modred_select_test.sv
`timescale 1ns/1ps
module modred_select_test;
    localparam int ZW = 24, NW = 20, SZW = 5, SI_MIN = -8, SI_MAX = 8;
    localparam int SIW = 5, SNW = 7;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                  rst, in_valid, in_binary;
    logic [ZW-1:0]         in_z;
    logic [NW-1:0]         in_n;
    logic [SZW-1:0]        in_sz;
    logic                  out_valid, out_sat;
    logic [1:0]            out_b;
    logic signed [SIW-1:0] out_si;
    logic signed [SNW-1:0] out_sn;

    modred_select uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_z(in_z), .in_n(in_n),
        .in_sz(in_sz), .in_binary(in_binary), .out_valid(out_valid),
        .out_b(out_b), .out_si(out_si), .out_sn(out_sn), .out_sat(out_sat)
    );

    typedef struct {
        bit     vld;
        int     b;
        int     si;
        int     sn;
        bit     sat;
        int     cat;
        longint a;
        longint n;
    } exp_t;

    int  tests = 0, fails = 0;
    bit  done = 0;
    exp_t d1, d2;

    function automatic string tag_of(input int cat);
        case (cat)
            1: return "R1";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic int dec_b(input logic [1:0] v);
        if (v == 2'b01) return 1;
        if (v == 2'b11) return -1;
        return 0;
    endfunction

    function automatic exp_t model(input bit vld, input logic [ZW-1:0] z,
                                   input logic [NW-1:0] n, input int sz, input bit bin);
        exp_t e;
        int zs;
        e = '{default: 0};
        e.vld = vld;
        zs = int'($signed(z));
        e.a = (zs < 0) ? -longint'(zs) : longint'(zs);
        e.n = longint'(n);
        if (z == '0) begin
            e.cat = 5;
        end else if (bin) begin
            int dz, dn, d;
            dz = -1; dn = -1;
            for (int i = 0; i < ZW; i++) if (z[i]) dz = i;
            for (int i = 0; i < NW; i++) if (n[i]) dn = i;
            if (dn < 0) begin
                e.si = SI_MIN; e.sat = 1; e.cat = 8;
            end else begin
                d = dn - dz;
                if (d > SI_MAX)      begin e.si = SI_MAX; e.sat = 1; e.cat = 8; end
                else if (d < SI_MIN) begin e.si = SI_MIN; e.sat = 1; e.cat = 8; end
                else                 begin e.si = d; e.b = 1; e.cat = 7; end
            end
        end else begin
            bit found;
            found = 0;
            for (int k = SI_MIN; k <= SI_MAX; k++) begin
                longint lhs, lo, hi;
                if (k >= 0) begin lhs = (3*e.a) << k; lo = 2*e.n; hi = 4*e.n; end
                else begin lhs = 3*e.a; lo = (2*e.n) << (-k); hi = (4*e.n) << (-k); end
                if (lo < lhs && lhs <= hi) begin e.si = k; found = 1; end
            end
            if (found) begin
                e.b = (zs < 0) ? 1 : -1; e.cat = 1;
            end else begin
                e.sat = 1; e.cat = 6;
                e.si = ((3*e.a) > ((4*e.n) << (-SI_MIN))) ? SI_MIN : SI_MAX;
            end
        end
        e.sn = sz - e.si;
        return e;
    endfunction

    task automatic check_out();
        tests++;
        if (out_valid !== d2.vld) begin
            fails++;
            $display("FAIL R4 valid: got %0b expected %0b", out_valid, d2.vld);
        end
        if (d2.vld && out_valid) begin
            tests++;
            if (int'(out_si) != d2.si || out_sat !== d2.sat) begin
                fails++;
                $display("FAIL %s si/sat: got %0d/%0b expected %0d/%0b",
                         tag_of(d2.cat), out_si, out_sat, d2.si, d2.sat);
            end
            tests++;
            if (dec_b(out_b) != d2.b) begin
                fails++;
                $display("FAIL %s b (R2 coding): got %0d expected %0d",
                         (d2.cat == 1) ? "R2" : tag_of(d2.cat), dec_b(out_b), d2.b);
            end
            tests++;
            if (int'(out_sn) != d2.sn) begin
                fails++;
                $display("FAIL R3 sn: got %0d expected %0d", out_sn, d2.sn);
            end
            if (d2.cat == 1) begin
                longint diff, lim;
                int s;
                s = int'(out_si);
                if (s >= 0) begin diff = (d2.a << s) - d2.n; lim = d2.n; end
                else begin diff = d2.a - (d2.n << (-s)); lim = d2.n << (-s); end
                if (diff < 0) diff = -diff;
                tests++;
                if (3*diff > lim) begin
                    fails++;
                    $display("FAIL R10 remainder: got 3*|r|=%0d expected <= %0d", 3*diff, lim);
                end
            end
        end
    endtask

    task automatic step(input bit vld, input logic [ZW-1:0] z, input logic [NW-1:0] n,
                        input int sz, input bit bin);
        @(negedge clk);
        check_out();
        d2 = d1;
        d1 = model(vld, z, n, sz, bin);
        in_valid  = vld;
        in_z      = z;
        in_n      = n;
        in_sz     = SZW'(sz);
        in_binary = bin;
    endtask

    initial begin
        rst = 1; in_valid = 0; in_z = '0; in_n = '0; in_sz = '0; in_binary = 0;
        d1 = '{default: 0};
        d2 = '{default: 0};
        repeat (3) @(negedge clk);
        tests++;
        if (out_valid !== 0 || out_b !== 2'b00 || out_si !== '0 || out_sn !== '0 || out_sat !== 0) begin
            fails++;
            $display("FAIL R9 reset: got v=%0b b=%0b si=%0d sn=%0d sat=%0b expected all zero",
                     out_valid, out_b, out_si, out_sn, out_sat);
        end
        rst = 0;

        // R1 inclusive four-thirds edge, both signs (R2)
        step(1, 24'd2, 20'd3, 4, 0);
        step(1, -24'sd2, 20'd3, 4, 0);
        step(1, 24'd4, 20'd3, 0, 0);
        step(1, 24'd1000, 20'd1000, 31, 0);
        // R5 zero, both modes
        step(1, 24'd0, 20'd77, 9, 0);
        step(1, 24'd0, 20'd77, 9, 1);
        // R6 clamps, including negative Z and zero modulus
        step(1, 24'h7FFFFF, 20'd1, 3, 0);
        step(1, 24'h800000, 20'd1, 3, 0);
        step(1, 24'd1, 20'h80001, 2, 0);
        step(1, -24'sd1, 20'h80001, 2, 0);
        step(1, 24'd5, 20'd0, 6, 0);
        // R7 / R8 binary degrees
        step(1, 24'h000100, 20'h01000, 10, 1);
        step(1, 24'h800000, 20'h08000, 1, 1);
        step(1, 24'h000010, 20'h80000, 1, 1);
        step(1, 24'h800000, 20'h00001, 1, 1);
        step(1, 24'h000033, 20'h00000, 1, 1);
        // R4 gaps
        step(0, 24'd9, 20'd9, 0, 0);
        step(1, 24'd9, 20'd9, 0, 0);
        step(0, 24'd0, 20'd0, 0, 0);

        for (int i = 0; i < 800; i++) begin
            logic [ZW-1:0] rz;
            logic [NW-1:0] rn;
            bit vld, bin;
            vld = ($urandom % 8) != 0;
            bin = ($urandom % 4) == 0;
            rn = NW'($urandom) >> ($urandom % NW);
            rz = ZW'($urandom) >> ($urandom % ZW);
            if ($urandom % 2) rz = ~rz + 1'b1;
            step(vld, rz, rn, int'($urandom % 32), bin);
        end
        repeat (3) step(0, '0, '0, 0, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R4 watchdog: got no end expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule